// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of a parameterised width over several clock cycles. It uses one adder of operand width plus one extra bit. It keeps the multiplicand in a hold register. The product is built in place inside a double-width accumulator pair: the upper half holds running partial sums and the lower half initially holds the multiplier. Each iteration examines the lowest bit of the lower half. When that bit is set, the iteration adds the multiplicand into the upper half. In the same clock edge, it shifts the whole pair right by one position, and the adder's carry-out becomes the new top bit.

A caller presents both operands and pulses `start` while the block is idle. The operands are captured on that edge. The block then stays busy for one edge per operand bit. When the result is ready, it raises `done` for a single cycle. The 2N-bit product stays on `product` until the next accepted start. A start that arrives while the block is busy has no effect.

Top module: `shift_add_mul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `product` is all zeros.
- R2: A `start` sampled high while `busy` is 0 captures both operands on that edge, and `busy` reads 1 in the following cycle.
- R3: The accepted start edge is followed by exactly WIDTH iteration edges. `busy` stays 1 until the last of them. On that last edge, `busy` returns to 0 and `done` rises. This means `done` is first seen WIDTH cycles after the cycle in which `busy` first read 1 was entered, counting from the start edge.
- R4: When `done` is 1, `product` equals the full unsigned 2*WIDTH-bit product of the captured operands. Bits [2*WIDTH-1:WIDTH] are the high half and bits [WIDTH-1:0] are the low half.
- R5: `done` is high for exactly one cycle per operation and is never high together with `busy`.
- R6: A `start` sampled while `busy` is 1 is ignored. Neither the running result nor the completion timing changes.
- R7: While idle and without a new start, `product` keeps its last value.
- R8: With WIDTH=3, multiplicand 3'b110 and multiplier 3'b101 give a high half of 3'b011 and a low half of 3'b110. This is 6'b011110, which equals 30.
- R9: The carry out of each addition is kept as the new top bit. All-ones times all-ones gives 2^(2*WIDTH) - 2^(WIDTH+1) + 1 with no bit lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply; used only when idle |
| multiplicand | input | WIDTH | Operand added on set multiplier bits |
| multiplier | input | WIDTH | Operand scanned from its least significant bit |
| busy | output | 1 | High while iterations are in progress |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Double-width unsigned product, held until the next accepted start |

## Verification
The bench multiplies all-ones by all-ones. If a design drops the adder carry instead of shifting it into the top bit, it returns a high half that is too small. A zero multiplier, zero multiplicand and unit operands show whether each iteration adds on the wrong bit or leaves stale contents in the upper half after the previous run. The bench also counts the edges between the start and `done`, so that running one iteration too few or too many shows up as a late or early pulse or a halved or doubled product. A second start fired in the middle of an operation catches a design that reloads its operands while busy. A three-bit instance is checked against the known 30 result.

// File: rtl/mul_pkg.sv
package mul_pkg;
  // Width of a counter able to index WIDTH iterations (at least one bit).
  function automatic int iter_cnt_width(input int width);
    return (width > 1) ? $clog2(width) : 1;
  endfunction
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl #(
  parameter int WIDTH = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = mul_pkg::iter_cnt_width(WIDTH);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic          done_q;
  logic          last;

  assign last = (cnt_q == LAST);
  assign load = start && !busy_q;
  assign step = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (step) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R2: an idle start makes the block busy on the next cycle
  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q);
  // R3: completion only follows a busy cycle
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_q |-> $past(busy_q));
  // R5: done is a single-cycle pulse, exclusive with busy
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !busy_q);
  // R6: a start while busy never restarts the iteration count
  assert_busy_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_q && start && !last) |=> (busy_q && cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               step,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] prod
);
  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] hold_q;  // multiplicand
  logic [WIDTH-1:0] hi_q;    // accumulator (upper half)
  logic [WIDTH-1:0] lo_q;    // multiplier / low product bits
  logic [SW-1:0]    addend;
  logic [SW-1:0]    sum;

  assign addend = lo_q[0] ? {1'b0, hold_q} : '0;
  assign sum    = {1'b0, hi_q} + addend;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (load) begin
      hold_q <= mcand_in;
      hi_q   <= '0;
      lo_q   <= mplier_in;
    end else if (step) begin
      // carry lands in the top bit, sum bit 0 moves into the low half
      {hi_q, lo_q} <= {sum, lo_q[WIDTH-1:1]};
    end
  end

  assign prod = {hi_q, lo_q};

  // R6: the multiplicand is never reloaded while iterating
  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
    step |=> $stable(hold_q));
  // R7: idle without load keeps the result
  assert_product_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!step && !load) |=> $stable(prod));
  // R2: a load clears the upper half
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (hi_q == '0));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load;
  logic step;

  mul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  mul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .step      (step),
    .mcand_in  (multiplicand),
    .mplier_in (multiplier),
    .prod      (product)
  );

  // R1: idle flags out of reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && product == '0));
endmodule

// File: tb/test_shift_add_mul.sv
module test_shift_add_mul;
  localparam int  W      = 32;
  localparam time CLK_PD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] mc = '0, mp = '0;
  logic busy, done;
  logic [2*W-1:0] product;

  logic start3 = 1'b0;
  logic [2:0] mc3 = '0, mp3 = '0;
  logic busy3, done3;
  logic [5:0] product3;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PD/2) clk = ~clk;

  shift_add_mul #(.WIDTH(W)) i_shift_add_mul (
    .clk(clk), .rst(rst), .start(start), .multiplicand(mc), .multiplier(mp),
    .busy(busy), .done(done), .product(product));

  shift_add_mul #(.WIDTH(3)) i_shift_add_mul_w3 (
    .clk(clk), .rst(rst), .start(start3), .multiplicand(mc3), .multiplier(mp3),
    .busy(busy3), .done(done3), .product(product3));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [63:0] x, y;
    x = 64'(a);
    y = 64'(b);
    return x * y;
  endfunction

  // One multiply; optionally fire a competing start mid-run (R6).
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    logic [63:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mc = a; mp = b; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1 && done == 1'b0, "R2 busy after start", {62'b0, busy, done}, 64'h2);
    for (int i = 1; i < W; i++) begin
      if (disturb && i == 5) begin
        mc = ~a; mp = ~b; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (i == W - 1)
        check(busy == 1'b1 && done == 1'b0, "R3 still busy before last edge",
              {62'b0, busy, done}, 64'h2);
    end
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R3/R5 done after WIDTH iterations",
          {62'b0, busy, done}, 64'h1);
    check(product == exp, disturb ? "R6 product with ignored start" : "R4 product", product, exp);
    @(posedge clk);
    @(negedge clk);
    check(done == 1'b0, "R5 done one cycle", {63'b0, done}, 64'h0);
    check(product == exp, "R7 product held", product, exp);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset state",
          product, 64'h0);

    // R8: three-bit worked example
    @(negedge clk);
    mc3 = 3'b110; mp3 = 3'b101; start3 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start3 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(done3 == 1'b0, "R8 no early done (3-bit)", {63'b0, done3}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    check(done3 == 1'b1 && product3 == 6'b011110, "R8 3-bit 110*101",
          {57'b0, done3, product3}, {57'b0, 1'b1, 6'b011110});

    // directed corners
    run_mul('0, '0, 1'b0);
    run_mul('1, '0, 1'b0);
    run_mul('0, '1, 1'b0);
    run_mul(32'd1, 32'd1, 1'b0);
    run_mul('1, 32'd1, 1'b0);
    run_mul(32'd1, '1, 1'b0);
    run_mul('1, '1, 1'b0);  // R9 carry into top bit
    check(product == 64'hFFFFFFFE00000001, "R9 all-ones square", product,
          64'hFFFFFFFE00000001);
    run_mul(32'h80000000, 32'h80000000, 1'b0);
    run_mul(32'hDEADBEEF, 32'h12345678, 1'b1);

    // random operands
    for (int k = 0; k < 40; k++) begin
      logic [W-1:0] a, b;
      a = $urandom;
      b = $urandom;
      run_mul(a, b, (k % 7) == 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule